// File: doc/BRIEF.md
# I2C Register Access Slave

This block lets an I2C bus master read and write a 128-entry register space held outside the block. It oversamples the SCL and SDA lines with the system clock and recognises START, repeated START and STOP. After a START it compares the 7-bit device address with a parameter. When the address matches and the read/write bit is 0, the next byte sets an internal register index, and every later byte is written to the register the index selects. A repeated START followed by the address with the read bit set makes the block shift register contents back to the master. The index steps by one after every byte that is moved and wraps from 0x7F to 0x00.

The register file sits next to the block. The block presents an index, write data and a one-cycle write strobe, and it reads back the addressed byte together with a flag that says whether that index holds a real register. The block answers writes that target an undefined register with no acknowledge. Reads return whatever byte the register file supplies, whether or not the index is defined. The block pulls SDA low through an open-drain enable; the pad and its pull-up are outside the block.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START followed by the address byte `{DEV_ADDR, 0}` (DEV_ADDR defaults to 0x4C, so the byte is 0x98) is acknowledged: `sda_oe` is 1 (SDA low) while SCL is high in the ninth bit.
- R2: An address byte whose upper 7 bits differ from DEV_ADDR gets no acknowledge. Every later byte up to the next START or STOP is ignored: no acknowledge, no write, and the index keeps its value.
- R3: In a write transfer, the byte after the address sets the index to its low 7 bits; bit 7 is ignored. The byte is acknowledged only when `reg_defined` is 1 for the new index.
- R4: Each data byte in a write transfer is taken MSB first. When its target is defined, the byte is acknowledged and written with a single-cycle `reg_we` pulse at the current index. The index then advances by one.
- R5: The index wraps from 0x7F to 0x00, both when writes advance it and when reads advance it.
- R6: A data byte aimed at an undefined index is not acknowledged and causes no write, and the index does not advance.
- R7: After a repeated START and the address byte `{DEV_ADDR, 1}` (0x99), the block acknowledges. It then returns the register at the index, MSB first, advancing the index by one after each byte.
- R8: When a read directly follows a transfer that wrote data, the first byte returned is the register written last, not the one after it.
- R9: A read returns `reg_rdata` at the index even when `reg_defined` is 0 there, for example at indexes 0x10 to 0x1F.
- R10: A master NACK after a read byte ends the read. The block releases SDA and drives nothing until the next START.
- R11: A STOP or START that arrives before the eighth bit of a byte discards that byte: no write, and the index is not loaded.
- R12: After reset, `sda_oe` and `reg_we` are 0 and the index is 0x00.
- R13: `sda_oe` changes only while SCL is low, so SDA is stable for the whole high phase of every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | IDX_W | Current register index |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe for `reg_addr` |
| reg_rdata | input | 8 | Byte stored at `reg_addr`, combinational from the register file |
| reg_defined | input | 1 | 1 when `reg_addr` names a real register |

## Verification
The checks assume that the register file answers `reg_rdata` and `reg_defined` for `reg_addr` within the same cycle. They also assume that the master moves SDA only while SCL is low, except to form START and STOP, and that it never signals a START or STOP while the block is pulling SDA low. Each SCL phase must last many system clocks, so that the synchronised edges arrive well before the next line change. The bench master runs SCL at 40 clocks per bit, moves SDA a quarter bit after each falling edge and models the bus as a wired AND. This keeps every transfer, including the deliberately cut ones, inside those limits.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  // bit counter landmarks within one byte slot
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);      // eight bits moved
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);  // inside ninth bit
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVADR,
    PH_INDEX,
    PH_WDATA,
    PH_RDATA
  } phase_t;
endpackage

// File: rtl/i2c_rs_line.sv
// Synchronises the bus lines and derives edge / condition events.
module i2c_rs_line #(
  parameter int SYNC_STAGES = 2   // must be 2 or more
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_now;
      sda_q  <= sda_now;
    end
  end

  assign scl_now   = scl_sh[SYNC_STAGES-1];
  assign sda_now   = sda_sh[SYNC_STAGES-1];
  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;
endmodule

// File: rtl/i2c_rs_index.sv
// Indirect register index with wrap, plus memory of the last written entry.
module i2c_rs_index #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             restore,
  input  logic             wr_done,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] last_wr;
  logic             wr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      last_wr <= '0;
      wr_pend <= 1'b0;
    end else if (load) begin
      idx     <= load_val;
      wr_pend <= 1'b0;
    end else if (restore) begin
      if (wr_pend) idx <= last_wr;
      wr_pend <= 1'b0;
    end else if (wr_done) begin
      last_wr <= idx;
      wr_pend <= 1'b1;
      idx     <= idx + ONE;
    end else if (step) begin
      idx     <= idx + ONE;
    end
  end
endmodule

// File: rtl/i2c_rs_fsm.sv
// Byte sequencing: address match, index capture, data write and data read.
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int         IDX_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              reg_defined,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              idx_load,
  output logic [IDX_W-1:0]  idx_load_val,
  output logic              idx_restore,
  output logic              idx_step
);
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  rx;
  logic [BYTE_W-2:0]  tx;
  logic               rw;
  logic               mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      cnt          <= '0;
      rx           <= '0;
      tx           <= '1;
      rw           <= 1'b0;
      mack         <= 1'b1;
      sda_oe       <= 1'b0;
      reg_we       <= 1'b0;
      reg_wdata    <= '0;
      idx_load     <= 1'b0;
      idx_load_val <= '0;
      idx_restore  <= 1'b0;
      idx_step     <= 1'b0;
    end else begin
      reg_we      <= 1'b0;
      idx_load    <= 1'b0;
      idx_restore <= 1'b0;
      idx_step    <= 1'b0;
      if (start_det) begin
        phase  <= PH_DEVADR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_DEVADR, PH_INDEX, PH_WDATA: begin
            if (scl_rise && cnt < CNT_FULL) begin
              rx  <= {rx[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (phase == PH_INDEX && cnt == CNT_LAST) begin
                idx_load     <= 1'b1;
                idx_load_val <= {rx[IDX_W-2:0], sda_s};
              end
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= CNT_ACK;
              case (phase)
                PH_DEVADR: begin
                  if (rx[BYTE_W-1:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    rw     <= rx[0];
                    if (rx[0]) idx_restore <= 1'b1;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                PH_INDEX: sda_oe <= reg_defined;
                default: begin
                  if (reg_defined) begin
                    sda_oe    <= 1'b1;
                    reg_we    <= 1'b1;
                    reg_wdata <= rx;
                  end
                end
              endcase
            end else if (scl_fall && cnt == CNT_ACK) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (phase == PH_DEVADR) begin
                if (rw) begin
                  phase  <= PH_RDATA;
                  tx     <= reg_rdata[BYTE_W-2:0];
                  sda_oe <= ~reg_rdata[BYTE_W-1];
                end else begin
                  phase <= PH_INDEX;
                end
              end else if (phase == PH_INDEX) begin
                phase <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            if (scl_rise && cnt < CNT_FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_rise && cnt == CNT_ACK) begin
              mack     <= sda_s;
              idx_step <= 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              cnt    <= CNT_ACK;
            end else if (scl_fall && cnt == CNT_ACK) begin
              if (!mack) begin
                tx     <= reg_rdata[BYTE_W-2:0];
                sda_oe <= ~reg_rdata[BYTE_W-1];
                cnt    <= '0;
              end else begin
                phase <= PH_IDLE;
                cnt   <= '0;
              end
            end else if (scl_fall && cnt != '0) begin
              sda_oe <= ~tx[BYTE_W-2];
              tx     <= {tx[BYTE_W-3:0], 1'b1};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         IDX_W       = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_defined
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic idx_load, idx_restore, idx_step;
  logic [IDX_W-1:0] idx_load_val;

  i2c_rs_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rs_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .reg_defined(reg_defined), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .idx_load(idx_load),
    .idx_load_val(idx_load_val), .idx_restore(idx_restore),
    .idx_step(idx_step)
  );

  i2c_rs_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst(rst), .load(idx_load), .load_val(idx_load_val),
    .restore(idx_restore), .wr_done(reg_we), .step(idx_step),
    .idx(reg_addr)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [IDX_W-1:0] reg_addr,
  input logic             reg_we,
  input logic             reg_defined
);
  // R12: outputs quiet once reset has been applied
  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> (!sda_oe && !reg_we && reg_addr == '0));

  // R13: the SDA driver only moves while SCL is low
  p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R4: write strobe lasts one cycle
  p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R6: never write an undefined register
  p_we_defined_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> reg_defined);

  // R5: a write advances the index by one, modulo the index width
  p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + IDX_W'(1)));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_defined(reg_defined)
);

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  localparam int H = 20;            // clocks per SCL half period
  localparam logic [7:0] AW = 8'h98; // address + write
  localparam logic [7:0] AR = 8'h99; // address + read

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we, reg_defined;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire  sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem  [128];
  logic [7:0] gold [128];

  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  int hi_glitch = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic is_def(input logic [6:0] a);
    return !((a >= 7'h10 && a <= 7'h1F) || (a >= 7'h40 && a <= 7'h47));
  endfunction

  assign reg_rdata   = mem[reg_addr];
  assign reg_defined = is_def(reg_addr);

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  i2c_reg_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_defined(reg_defined)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected write for every strobe seen (R4, R6)
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 unexpected write actual=%0h:%0h expected=none", reg_addr, reg_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check("R4 write addr:data", {17'd0, reg_addr, reg_wdata}, {17'd0, e.a, e.d});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    tick(H/2); sda_m = 1'b1; tick(H/2); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(H/2); sda_m = 1'b0; tick(H/2); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    tick(H/2); sda_m = b; tick(H/2); scl = 1'b1; tick(H); scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    logic late;
    tick(H/2); sda_m = 1'b1; tick(H/2); scl = 1'b1; tick(2); b = sda_bus;
    tick(H-3); late = sda_bus; tick(1); scl = 1'b0;
    if (late !== b) hi_glitch++;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack_it);
  endtask

  task automatic send_chk(input string tag, input logic [7:0] v, input logic exp_ack);
    logic a;
    put_byte(v, a);
    check(tag, {31'd0, a}, {31'd0, exp_ack});
  endtask

  // driver: pushes the expected write before sending the byte
  task automatic data_wr(input string tag, input logic [7:0] v, input logic [6:0] a);
    logic d;
    d = is_def(a);
    if (d) begin
      exp_q.push_back('{a: a, d: v});
      gold[a] = v;
    end
    send_chk(tag, v, d);
  endtask

  task automatic read_chk(input string tag, input logic [6:0] a, input logic ack_it);
    logic [7:0] v;
    get_byte(ack_it, v);
    check(tag, {24'd0, v}, {24'd0, gold[a]});
  endtask

  initial begin : wd
    int c;
    c = 0;
    while (!done && c < 150000) begin @(posedge clk); c++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 128; i++) begin
      mem[i]  = 8'(i) ^ 8'hA5;
      gold[i] = 8'(i) ^ 8'hA5;
    end
    tick(10);
    rst = 1'b0;
    tick(5);
    // R12 reset state
    check("R12 sda_oe", {31'd0, sda_oe}, 32'd0);
    check("R12 reg_we", {31'd0, reg_we}, 32'd0);
    check("R12 index", {25'd0, reg_addr}, 32'd0);

    // R1 R3 R4 plain write burst
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h05, 1'b1);
    data_wr("R4 data ack", 8'h11, 7'h05);
    data_wr("R4 data ack", 8'h22, 7'h06);
    data_wr("R4 data ack", 8'h33, 7'h07);
    bus_stop;
    check("R4 index advanced", {25'd0, reg_addr}, 32'h08);

    // R7 read burst, R3 with index bit 7 set
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index 0x85 ack", 8'h85, 1'b1);
    bus_start;
    send_chk("R7 read address ack", AR, 1'b1);
    read_chk("R7 read byte", 7'h05, 1'b1);
    read_chk("R7 read byte", 7'h06, 1'b1);
    read_chk("R7 read byte", 7'h07, 1'b0);
    bus_stop;

    // R8 first read after a write
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h20, 1'b1);
    data_wr("R4 data ack", 8'h5A, 7'h20);
    bus_start;
    send_chk("R7 read address ack", AR, 1'b1);
    read_chk("R8 last written", 7'h20, 1'b1);
    read_chk("R7 next byte", 7'h21, 1'b0);
    bus_stop;
    check("R7 index after reads", {25'd0, reg_addr}, 32'h22);

    // R5 wrap on writes and reads
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h7E, 1'b1);
    data_wr("R5 data 7E", 8'hC1, 7'h7E);
    data_wr("R5 data 7F", 8'hC2, 7'h7F);
    data_wr("R5 data 00", 8'hC3, 7'h00);
    bus_stop;
    check("R5 index wrapped", {25'd0, reg_addr}, 32'h01);
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h7F, 1'b1);
    bus_start;
    send_chk("R7 read address ack", AR, 1'b1);
    read_chk("R5 read 7F", 7'h7F, 1'b1);
    read_chk("R5 read 00", 7'h00, 1'b0);
    bus_stop;

    // R6 undefined targets
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 undefined index nack", 8'h12, 1'b0);
    data_wr("R6 undefined data nack", 8'h77, 7'h12);
    bus_stop;
    check("R6 index held", {25'd0, reg_addr}, 32'h12);
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h3F, 1'b1);
    data_wr("R4 data ack", 8'hD1, 7'h3F);
    data_wr("R6 undefined data nack", 8'hD2, 7'h40);
    bus_stop;
    check("R6 index held", {25'd0, reg_addr}, 32'h40);

    // R9 reads of an undefined range still return data
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 undefined index nack", 8'h15, 1'b0);
    bus_start;
    send_chk("R7 read address ack", AR, 1'b1);
    read_chk("R9 undefined read", 7'h15, 1'b1);
    read_chk("R9 undefined read", 7'h16, 1'b0);
    bus_stop;

    // R2 foreign address ignored
    bus_start;
    send_chk("R2 foreign address", 8'h9A, 1'b0);
    send_chk("R2 ignored byte", 8'h05, 1'b0);
    send_chk("R2 ignored byte", 8'hEE, 1'b0);
    bus_stop;
    check("R2 index unchanged", {25'd0, reg_addr}, 32'h17);

    // R11 aborted bytes
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h50, 1'b1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop;
    check("R11 stop mid-byte", {25'd0, reg_addr}, 32'h50);
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start;
    check("R11 start mid-index", {25'd0, reg_addr}, 32'h50);
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h52, 1'b1);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h52, 1'b1);
    data_wr("R11 write after restart", 8'h99, 7'h52);
    bus_stop;
    check("R11 index", {25'd0, reg_addr}, 32'h53);

    // R10 NACK ends the read
    bus_start;
    send_chk("R1 address ack", AW, 1'b1);
    send_chk("R3 index ack", 8'h60, 1'b1);
    bus_start;
    send_chk("R7 read address ack", AR, 1'b1);
    read_chk("R10 last read byte", 7'h60, 1'b0);
    get_byte(1'b0, v);
    check("R10 bus released", {24'd0, v}, 32'hFF);
    bus_stop;
    check("R10 index", {25'd0, reg_addr}, 32'h61);

    tick(20);
    check("R13 SDA stable while SCL high", hi_glitch, 0);
    check("R4 pending writes", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule